// File: doc/BRIEF.md
# Static RAM with Selectable Bulk Clear

A synchronous 1024-word by 4-bit memory. It has a separate input path and a separate output path, and four active-low controls: select, write, output enable and clear. Commands are sampled on the rising clock edge. Read data is registered and comes out one cycle later, together with a modelled output-enable flag. This flag stands in for tri-state drive, and the data bus reads zero whenever the flag is low.

The storage is 64 rows of 64 bits. Address bits [9:4] pick the row, and address bits [3:0] pick one of the sixteen 4-bit words in that row. A clear command given while the device is selected erases the whole array in two clock edges. A two-state sequencer, `SEQ_IDLE` and `SEQ_UPPER`, controls the clear:

- The command edge zeroes rows 0..31 and moves `SEQ_IDLE` to `SEQ_UPPER`. This is the start transition.
- The next edge zeroes rows 32..63 and returns to `SEQ_IDLE`. This is the finish transition.
- A new clear command seen in `SEQ_UPPER` takes the restart transition. The sequencer stays in `SEQ_UPPER` and clears both halves on that edge.

Because a clear needs the device to be selected, a reset line shared by many devices erases only the selected ones.

Top module: `sram_bulkclr`

## Requirements
- R1: While `cs_ni` is 1 no word changes, no clear starts, and on the next cycle `dout_en_o` is 0 and `dout_o` is 0.
- R2: With `cs_ni`=0, `clr_ni`=1, `we_ni`=0 and `busy_o`=0 at an edge, `din_i` is stored in the word at `addr_i`.
- R3: With `cs_ni`=0, `clr_ni`=1, `we_ni`=1 and `oe_ni`=0 at an edge, after that edge `dout_en_o`=1 and `dout_o` holds the addressed word. A word written at the previous edge reads back as its new value.
- R4: In every other mode (`oe_ni`=1, `we_ni`=0, `clr_ni`=0 or deselected), `dout_en_o` and `dout_o` are 0 after the edge.
- R5: `cs_ni`=0 with `clr_ni`=0 zeroes every word within two edges. `busy_o` is 1 for exactly the one cycle between those two edges.
- R6: `clr_ni`=0 while `cs_ni`=1 is ignored: contents are kept and `busy_o` stays 0.
- R7: When `clr_ni` and `we_ni` are both 0 with the device selected, the clear wins and no write occurs.
- R8: A read issued while `busy_o`=1 returns 0 for addresses with bit 9 = 0, which are already cleared. For addresses with bit 9 = 1 it returns the word's value from before the clear.
- R9: A write issued while `busy_o`=1 is discarded.
- R10: The row is taken from `addr_i[9:4]` and the word within the row from `addr_i[3:0]`. All 1024 addresses hold independent words.
- R11: While `rst_ni`=0, and right after it is released, `busy_o`, `dout_en_o` and `dout_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset of the sequencer and output register (not the array) |
| cs_ni | input | 1 | Active-low device select |
| we_ni | input | 1 | Active-low write command |
| oe_ni | input | 1 | Active-low output enable |
| clr_ni | input | 1 | Active-low bulk-clear command |
| addr_i | input | 10 | Word address |
| din_i | input | 4 | Write data |
| dout_o | output | 4 | Read data, zero when not enabled |
| dout_en_o | output | 1 | Modelled output drive enable |
| busy_o | output | 1 | Clear of the upper half is pending |

## Verification
Every result of this block is due exactly one edge after the command that causes it:

- read data and the output-enable flag appear one edge after the read command;
- `busy_o` rises one edge after a clear command and falls one edge later;
- a stored word can be seen by a read issued in the very next cycle.

The bench drives each command at a falling edge. Just after the following rising edge it updates a behavioural model: it computes the read result from the contents before the edge, then applies the pending upper-half clear, the new lower-half clear and any permitted write. It compares all three outputs with the model once per cycle, so every result is checked in the single cycle it becomes due.

// File: rtl/sram_bc_pkg.sv
package sram_bc_pkg;

    typedef enum logic [2:0] {
        MODE_DESEL,
        MODE_CLEAR,
        MODE_WRITE,
        MODE_READ,
        MODE_HOLD
    } mode_e;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_UPPER
    } seq_e;

endpackage

// File: rtl/sram_bc_decode.sv
module sram_bc_decode
    import sram_bc_pkg::*;
(
    input  logic  cs_n,
    input  logic  clr_n,
    input  logic  we_n,
    input  logic  oe_n,
    output mode_e mode
);

    // Priority: deselect, then clear, then write, then read.
    always_comb begin
        unique casez ({cs_n, clr_n, we_n, oe_n})
            4'b1???: mode = MODE_DESEL;
            4'b00??: mode = MODE_CLEAR;
            4'b010?: mode = MODE_WRITE;
            4'b0110: mode = MODE_READ;
            4'b0111: mode = MODE_HOLD;
            default: mode = MODE_DESEL;
        endcase
    end

endmodule

// File: rtl/sram_bc_seq.sv
module sram_bc_seq
    import sram_bc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic clr_lo,
    output logic clr_hi,
    output logic busy
);

    seq_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (start) state_d = SEQ_UPPER;
            SEQ_UPPER: state_d = start ? SEQ_UPPER : SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        clr_lo = start;
        clr_hi = 1'b0;
        busy   = 1'b0;
        unique case (state_q)
            SEQ_IDLE:  ;
            SEQ_UPPER: begin
                clr_hi = 1'b1;
                busy   = 1'b1;
            end
            default: ;
        endcase
    end

    // R5
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R5
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> !busy);

endmodule

// File: rtl/sram_bc_array.sv
module sram_bc_array #(
    parameter int ROW_W = 6,
    parameter int SEL_W = 4,
    parameter int DW    = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             clr_lo,
    input  logic             clr_hi,
    input  logic [ROW_W-1:0] row,
    input  logic [SEL_W-1:0] sel,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    rd_data
);

    localparam int NROWS = 1 << ROW_W;
    localparam int WPR   = 1 << SEL_W;
    localparam int HALF  = NROWS / 2;

    typedef logic [WPR-1:0][DW-1:0] row_t;

    row_t row_q [NROWS];

    for (genvar g = 0; g < NROWS; g++) begin : g_row
        row_t q;
        logic clr_this;
        if (g < HALF) begin : g_lower
            assign clr_this = clr_lo;
        end else begin : g_upper
            assign clr_this = clr_hi;
        end
        always_ff @(posedge clk) begin
            if (clr_this)                            q <= '0;
            else if (wr_en && row == ROW_W'(g))      q[sel] <= din;
        end
        assign row_q[g] = q;
    end

    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rd_en) rd_q <= row_q[row][sel];
    end

    assign rd_data = rd_q;

    // R5
    lower_cleared_chk: assert property (@(posedge clk)
        clr_lo |=> (row_q[0] == '0));

    // R5
    upper_cleared_chk: assert property (@(posedge clk)
        clr_hi |=> (row_q[NROWS-1] == '0));

endmodule

// File: rtl/sram_bc_out.sv
module sram_bc_out #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    logic en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= rd_en;
    end

    assign dout_en = en_q;
    assign dout    = en_q ? rd_data : '0;

    // R4
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!dout_en && dout == '0));

endmodule

// File: rtl/sram_bulkclr.sv
module sram_bulkclr
    import sram_bc_pkg::*;
#(
    parameter int ROW_W = 6,
    parameter int SEL_W = 4,
    parameter int DW    = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   cs_ni,
    input  logic                   we_ni,
    input  logic                   oe_ni,
    input  logic                   clr_ni,
    input  logic [ROW_W+SEL_W-1:0] addr_i,
    input  logic [DW-1:0]          din_i,
    output logic [DW-1:0]          dout_o,
    output logic                   dout_en_o,
    output logic                   busy_o
);

    localparam int ADDR_W = ROW_W + SEL_W;

    mode_e mode;
    logic  clr_lo, clr_hi, busy;
    logic  wr_en, rd_en, start;
    logic [DW-1:0] rd_data;

    sram_bc_decode u_dec (
        .cs_n  (cs_ni),
        .clr_n (clr_ni),
        .we_n  (we_ni),
        .oe_n  (oe_ni),
        .mode  (mode)
    );

    assign start = (mode == MODE_CLEAR);
    assign rd_en = (mode == MODE_READ);
    assign wr_en = (mode == MODE_WRITE) && !busy;

    sram_bc_seq u_seq (
        .clk    (clk_i),
        .rst_n  (rst_ni),
        .start  (start),
        .clr_lo (clr_lo),
        .clr_hi (clr_hi),
        .busy   (busy)
    );

    sram_bc_array #(.ROW_W(ROW_W), .SEL_W(SEL_W), .DW(DW)) u_arr (
        .clk     (clk_i),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .clr_lo  (clr_lo),
        .clr_hi  (clr_hi),
        .row     (addr_i[ADDR_W-1:SEL_W]),
        .sel     (addr_i[SEL_W-1:0]),
        .din     (din_i),
        .rd_data (rd_data)
    );

    sram_bc_out #(.DW(DW)) u_out (
        .clk     (clk_i),
        .rst_n   (rst_ni),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .dout    (dout_o),
        .dout_en (dout_en_o)
    );

    assign busy_o = busy;

    // R1
    deselect_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_ni |=> !dout_en_o);

    // R6
    deselect_no_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_ni && !busy_o) |=> !busy_o);

endmodule

// File: tb/sram_bulkclr_bench.sv
module sram_bulkclr_bench;

    localparam int PERIOD = 10;
    localparam int NW     = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, clr_n = 1'b1;
    logic [9:0] addr = '0;
    logic [3:0] din = '0;
    logic [3:0] dout;
    logic       dout_en, busy;

    int checks = 0;
    int errors = 0;

    logic [3:0] mem [NW];
    logic [3:0] m_dout = '0;
    logic       m_en = 1'b0;
    logic       m_busy = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    sram_bulkclr u_sram_bulkclr (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .cs_ni     (cs_n),
        .we_ni     (we_n),
        .oe_ni     (oe_n),
        .clr_ni    (clr_n),
        .addr_i    (addr),
        .din_i     (din),
        .dout_o    (dout),
        .dout_en_o (dout_en),
        .busy_o    (busy)
    );

    task automatic compare(input string tag);
        checks++;
        if (dout !== m_dout || dout_en !== m_en || busy !== m_busy) begin
            errors++;
            $display("FAIL %s: got en=%b dout=%h busy=%b, expected en=%b dout=%h busy=%b",
                     tag, dout_en, dout, busy, m_en, m_dout, m_busy);
        end
    endtask

    // one clock: drive at falling edge, update model after rising edge, compare
    task automatic cyc(input logic cs, input logic clr, input logic we, input logic oe,
                       input logic [9:0] a, input logic [3:0] d, input string tag);
        bit is_rd, is_clr, is_wr;
        @(negedge clk);
        cs_n = cs; clr_n = clr; we_n = we; oe_n = oe; addr = a; din = d;
        @(posedge clk);
        #1;
        is_clr = !cs && !clr;
        is_wr  = !cs && clr && !we;
        is_rd  = !cs && clr && we && !oe;
        if (is_rd) begin m_en = 1'b1; m_dout = mem[a]; end
        else       begin m_en = 1'b0; m_dout = '0;     end
        if (m_busy) for (int i = NW/2; i < NW; i++) mem[i] = '0;
        if (is_clr) for (int i = 0; i < NW/2; i++) mem[i] = '0;
        if (is_wr && !m_busy) mem[a] = d;
        m_busy = is_clr;
        compare(tag);
    endtask

    task automatic wr(input logic [9:0] a, input logic [3:0] d, input string tag);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [9:0] a, input string tag);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, a, 4'h0, tag);
    endtask

    task automatic idle(input string tag);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 10'h0, 4'h0, tag);
    endtask

    task automatic clear(input string tag);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 10'h0, 4'h0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        compare("R11 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        idle("R11 after release");

        // R5: first clear, busy in between
        clear("R5 clear cmd");
        idle("R5 busy cycle");
        idle("R5 finished");

        // R2 / R10: distinct words across rows and columns
        for (int i = 0; i < 64; i++) begin
            wr(10'((i << 4) | (i & 15)), 4'((i * 7 + 3) & 15), "R2 R10 write");
        end
        wr(10'h3FF, 4'hC, "R2 top address");
        wr(10'h000, 4'h9, "R2 bottom address");
        wr(10'h001, 4'h6, "R10 neighbour word");
        for (int i = 0; i < 64; i++) begin
            rd(10'((i << 4) | (i & 15)), "R3 R10 readback");
        end
        rd(10'h3FF, "R3 top");
        rd(10'h000, "R3 bottom");
        rd(10'h001, "R10 neighbour");

        // R3: read right after write
        wr(10'h155, 4'hA, "R2 write");
        rd(10'h155, "R3 read after write");
        wr(10'h2AA, 4'h5, "R2 write");
        rd(10'h2AA, "R3 read after write");
        rd(10'h155, "R3 back to back");

        // R1 / R6: deselected writes and clears ignored
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 10'h000, 4'hF, "R1 deselected write");
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 10'h000, 4'h0, "R6 deselected clear");
        idle("R6 no busy");
        rd(10'h000, "R1 R6 word kept");
        rd(10'h2AA, "R6 upper kept");

        // R4: output disabled modes
        rd(10'h155, "R3 enable");
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 10'h155, 4'h0, "R4 oe high");
        rd(10'h155, "R3 enable again");
        wr(10'h010, 4'h3, "R4 write hides output");
        rd(10'h010, "R3 read");

        // R7: clear beats write
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 10'h005, 4'hF, "R7 clear with write");
        idle("R7 busy");
        rd(10'h005, "R7 no write");
        rd(10'h3FF, "R5 all cleared upper");
        rd(10'h000, "R5 all cleared lower");

        // R8: reads during busy
        wr(10'h003, 4'hA, "R2 lower fill");
        wr(10'h258, 4'h5, "R2 upper fill");
        clear("R8 clear cmd");
        rd(10'h258, "R8 upper old data");
        rd(10'h258, "R8 upper now clear");
        wr(10'h003, 4'hA, "R2 lower refill");
        clear("R8 clear cmd 2");
        rd(10'h003, "R8 lower already clear");

        // R9: write during busy discarded
        wr(10'h00A, 4'h7, "R2 pre");
        clear("R9 clear cmd");
        wr(10'h00A, 4'h7, "R9 write while busy");
        rd(10'h00A, "R9 discarded");
        wr(10'h20A, 4'h7, "R2 upper");
        clear("R9 clear cmd 2");
        wr(10'h20A, 4'h4, "R9 upper write while busy");
        rd(10'h20A, "R9 upper discarded");

        // R5: restart while busy
        wr(10'h100, 4'h1, "R2 lower");
        wr(10'h300, 4'h2, "R2 upper");
        clear("R5 clear cmd");
        clear("R5 restart");
        idle("R5 busy after restart");
        rd(10'h100, "R5 lower zero");
        rd(10'h300, "R5 upper zero");
        idle("R4 idle");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule